// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a processor from an instruction boundary into an exception handler. At each completed instruction it looks at the causes that are pending. These are an instruction fault, a software trap with a number from 0 to 15, single-step tracing, and an external interrupt level from 1 to 7. It picks one cause and switches the status word into supervisor mode. It then writes the return context onto the supervisor stack and reads the handler address from a vector table. The table sits at a base register that can be moved.

The block owns the status word, the user and supervisor stack pointers and the table base. The core loads the status word and both stack pointers through a context port, and loads the base through a separate write port. The block has one simple bus. A request completes in the cycle `bus_ack` is high, and `bus_err` marks the access as failed. When entry completes, the handler address appears on `handler_pc` with a one-cycle `handler_valid`. When entry cannot complete safely, the block stops in a halted state that only reset ends.

Top module: `exc_entry`

## Requirements
- R1: After reset the status word is 0x2700, both stack pointers and the table base are 0, and `busy`, `halted` and `handler_valid` are low.
- R2: Entry starts only in a cycle where `insn_done` is high while the block is idle. A pending cause with `insn_done` low starts nothing.
- R3: When several causes are pending, a fault wins over a trap, a trap wins over trace, and trace wins over an interrupt.
- R4: `fault_code` holds the table offset divided by four. The listed codes are bus error 2, address error 3, illegal 4, divide by zero 5, bounds 6, overflow trap 7, privilege 8, line A 10, line F 11 and format error 14. Any other code is served through offset 0x10.
- R5: Trap n reads offset 0x80+4n, interrupt level n reads offset 0x60+4n, and trace reads offset 0x24.
- R6: An interrupt is taken only when its level is above the mask in status bits 10:8, or when its level is 7. Once taken, the mask becomes that level.
- R7: On entry, status bit 13 (supervisor) is set and bit 15 (trace) is cleared. The active stack pointer `sp_out` then shows the supervisor stack pointer.
- R8: The return PC is written first, as a long word at SSP-4. The old status word is written next, as a 16-bit word at SSP-6. The supervisor stack pointer ends at SSP-6.
- R9: The handler address is read as a long word at base+offset. A non-zero value is output on `handler_pc` with `handler_valid` high for exactly one cycle.
- R10: If the vector read is zero, offset 0x3C is read instead. If that read is also zero, the block halts.
- R11: An odd supervisor stack pointer at entry, or `bus_err` on any entry access, makes the block halt without a further entry. Once halted, the block stays halted and issues no bus requests until reset.
- R12: With status bit 15 set, an instruction boundary that has no fault or trap takes the trace exception.
- R13: Context and base writes take effect only while the block is idle. While an entry is running they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| insn_done | input | 1 | Current instruction has completed |
| ret_pc | input | AW | PC to be saved on entry |
| fault_valid | input | 1 | An instruction fault is pending |
| fault_code | input | 4 | Fault code (offset divided by four) |
| trap_valid | input | 1 | A trap instruction is pending |
| trap_num | input | 4 | Trap number |
| irq_level | input | 3 | External interrupt level, 0 means none |
| ctx_we | input | 1 | Load status word and stack pointers |
| ctx_sr | input | 16 | Status word to load |
| ctx_usp | input | AW | User stack pointer to load |
| ctx_ssp | input | AW | Supervisor stack pointer to load |
| vbase_we | input | 1 | Load vector table base |
| vbase_in | input | AW | Vector table base to load |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_long | output | 1 | Long-word access (else 16-bit) |
| bus_addr | output | AW | Access address |
| bus_wdata | output | AW | Write data |
| bus_ack | input | 1 | Access completes this cycle |
| bus_err | input | 1 | Completing access failed |
| bus_rdata | input | AW | Read data |
| busy | output | 1 | Entry running or halted |
| handler_pc | output | AW | Handler address |
| handler_valid | output | 1 | One-cycle strobe for `handler_pc` |
| halted | output | 1 | Block has stopped |
| sr_out | output | 16 | Current status word |
| sp_out | output | AW | Active stack pointer |

## Verification
Cause selection is tested with patterns that hold one cause alone and with patterns that stack two to four causes at once. A wrong priority order therefore shows up as a wrong vector read address. Interrupt levels are tried below, at and above the mask, and with level 7 against a full mask, which separates strict from non-strict comparison and tests the non-maskable rule. Entries from user mode and from supervisor mode, with trace on and off, show whether the stacked status word is the old one and the live one is the updated one. Zero vector entries, an odd stack pointer and an injected bus error drive each of the two fallback paths and each halt path.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int TRAP_W = 4;
   localparam int LVL_W  = 3;
   localparam int OFF_W  = 8;

   localparam logic [OFF_W-1:0] OFF_TRACE  = 8'h24;
   localparam logic [OFF_W-1:0] OFF_UNINIT = 8'h3C;
   localparam logic [OFF_W-1:0] OFF_ILLEGAL = 8'h10;
   localparam logic [OFF_W-1:0] OFF_IRQ_BASE  = 8'h60;
   localparam logic [OFF_W-1:0] OFF_TRAP_BASE = 8'h80;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH_PC,
      ST_PUSH_SR,
      ST_FETCH,
      ST_HALT
   } seq_state_e;

   // fault code is the table offset divided by four
   function automatic logic [OFF_W-1:0] fault_offset(input logic [3:0] code);
      case (code)
         4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd10, 4'd11, 4'd14:
            fault_offset = {2'b00, code, 2'b00};
         default: fault_offset = OFF_ILLEGAL;
      endcase
   endfunction
endpackage

// File: rtl/exc_prio.sv
module exc_prio
   import exc_pkg::*;
(
   input  logic              fault_valid,
   input  logic [3:0]        fault_code,
   input  logic              trap_valid,
   input  logic [TRAP_W-1:0] trap_num,
   input  logic              trace_on,
   input  logic [LVL_W-1:0]  irq_level,
   input  logic [LVL_W-1:0]  mask,
   output logic              take,
   output logic              is_irq,
   output logic [OFF_W-1:0]  off
);
   logic irq_ok;

   assign irq_ok = (irq_level != '0) &&
                   ((irq_level == {LVL_W{1'b1}}) || (irq_level > mask));

   always_comb begin
      take   = 1'b1;
      is_irq = 1'b0;
      off    = '0;
      if (fault_valid) begin
         off = fault_offset(fault_code);
      end else if (trap_valid) begin
         off = OFF_TRAP_BASE + {{(OFF_W-TRAP_W-2){1'b0}}, trap_num, 2'b00};
      end else if (trace_on) begin
         off = OFF_TRACE;
      end else if (irq_ok) begin
         is_irq = 1'b1;
         off    = OFF_IRQ_BASE + {{(OFF_W-LVL_W-2){1'b0}}, irq_level, 2'b00};
      end else begin
         take = 1'b0;
      end
   end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
   import exc_pkg::*;
#(
   parameter int          AW          = 32,
   parameter bit          ODD_SP_HALT = 1'b1,
   parameter logic [15:0] RESET_SR    = 16'h2700
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             insn_done,
   input  logic [AW-1:0]    ret_pc,
   input  logic             take,
   input  logic             is_irq,
   input  logic [OFF_W-1:0] off,
   input  logic [LVL_W-1:0] irq_level,
   input  logic             ctx_we,
   input  logic [15:0]      ctx_sr,
   input  logic [AW-1:0]    ctx_usp,
   input  logic [AW-1:0]    ctx_ssp,
   input  logic             vbase_we,
   input  logic [AW-1:0]    vbase_in,
   output logic             bus_req,
   output logic             bus_we,
   output logic             bus_long,
   output logic [AW-1:0]    bus_addr,
   output logic [AW-1:0]    bus_wdata,
   input  logic             bus_ack,
   input  logic             bus_err,
   input  logic [AW-1:0]    bus_rdata,
   output logic             busy,
   output logic [AW-1:0]    handler_pc,
   output logic             handler_valid,
   output logic             halted,
   output logic [15:0]      sr_out,
   output logic [AW-1:0]    sp_out
);
   seq_state_e       st_q;
   logic [15:0]      sr_q, sr_saved_q;
   logic [AW-1:0]    usp_q, ssp_q, vbase_q, pc_q, hpc_q;
   logic [OFF_W-1:0] off_q;
   logic             retry_q, hval_q, sp_bad;

   generate
      if (ODD_SP_HALT) begin : g_odd_chk
         assign sp_bad = ssp_q[0];
      end else begin : g_no_odd_chk
         assign sp_bad = 1'b0;
      end
   endgenerate

   always_comb begin
      bus_req   = (st_q == ST_PUSH_PC) || (st_q == ST_PUSH_SR) || (st_q == ST_FETCH);
      bus_we    = (st_q == ST_PUSH_PC) || (st_q == ST_PUSH_SR);
      bus_long  = (st_q != ST_PUSH_SR);
      bus_addr  = '0;
      bus_wdata = '0;
      case (st_q)
         ST_PUSH_PC: begin
            bus_addr  = ssp_q - AW'(4);
            bus_wdata = pc_q;
         end
         ST_PUSH_SR: begin
            bus_addr  = ssp_q - AW'(2);
            bus_wdata = {{(AW-16){1'b0}}, sr_saved_q};
         end
         ST_FETCH: bus_addr = vbase_q + {{(AW-OFF_W){1'b0}}, off_q};
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         sr_q       <= RESET_SR;
         sr_saved_q <= '0;
         usp_q      <= '0;
         ssp_q      <= '0;
         vbase_q    <= '0;
         pc_q       <= '0;
         hpc_q      <= '0;
         off_q      <= '0;
         retry_q    <= 1'b0;
         hval_q     <= 1'b0;
      end else begin
         hval_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (vbase_we) vbase_q <= vbase_in;
               if (insn_done && take) begin
                  sr_saved_q <= sr_q;
                  pc_q       <= ret_pc;
                  off_q      <= off;
                  retry_q    <= 1'b0;
                  sr_q[13]   <= 1'b1;
                  sr_q[15]   <= 1'b0;
                  if (is_irq) sr_q[10:8] <= irq_level;
                  st_q <= sp_bad ? ST_HALT : ST_PUSH_PC;
               end else if (ctx_we) begin
                  sr_q  <= ctx_sr;
                  usp_q <= ctx_usp;
                  ssp_q <= ctx_ssp;
               end
            end
            ST_PUSH_PC: if (bus_ack) begin
               if (bus_err) st_q <= ST_HALT;
               else begin
                  ssp_q <= ssp_q - AW'(4);
                  st_q  <= ST_PUSH_SR;
               end
            end
            ST_PUSH_SR: if (bus_ack) begin
               if (bus_err) st_q <= ST_HALT;
               else begin
                  ssp_q <= ssp_q - AW'(2);
                  st_q  <= ST_FETCH;
               end
            end
            ST_FETCH: if (bus_ack) begin
               if (bus_err) st_q <= ST_HALT;
               else if (bus_rdata == '0) begin
                  if (retry_q) st_q <= ST_HALT;
                  else begin
                     retry_q <= 1'b1;
                     off_q   <= OFF_UNINIT;
                  end
               end else begin
                  hpc_q  <= bus_rdata;
                  hval_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end
            end
            default: st_q <= ST_HALT;
         endcase
      end
   end

   assign busy          = (st_q != ST_IDLE);
   assign halted        = (st_q == ST_HALT);
   assign handler_pc    = hpc_q;
   assign handler_valid = hval_q;
   assign sr_out        = sr_q;
   assign sp_out        = sr_q[13] ? ssp_q : usp_q;

   // R11
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);
   // R11
   halt_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !bus_req);
   // R9
   hval_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      handler_valid |=> !handler_valid);
   // R2
   entry_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(insn_done));
   // R7
   bus_super_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> sr_out[13]);
   // R8
   sr_push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && !bus_long) |-> $past(bus_req && bus_we && bus_long));
endmodule

// File: rtl/exc_entry.sv
module exc_entry
   import exc_pkg::*;
#(
   parameter int          AW          = 32,
   parameter bit          ODD_SP_HALT = 1'b1,
   parameter logic [15:0] RESET_SR    = 16'h2700
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          insn_done,
   input  logic [AW-1:0] ret_pc,
   input  logic          fault_valid,
   input  logic [3:0]    fault_code,
   input  logic          trap_valid,
   input  logic [3:0]    trap_num,
   input  logic [2:0]    irq_level,
   input  logic          ctx_we,
   input  logic [15:0]   ctx_sr,
   input  logic [AW-1:0] ctx_usp,
   input  logic [AW-1:0] ctx_ssp,
   input  logic          vbase_we,
   input  logic [AW-1:0] vbase_in,
   output logic          bus_req,
   output logic          bus_we,
   output logic          bus_long,
   output logic [AW-1:0] bus_addr,
   output logic [AW-1:0] bus_wdata,
   input  logic          bus_ack,
   input  logic          bus_err,
   input  logic [AW-1:0] bus_rdata,
   output logic          busy,
   output logic [AW-1:0] handler_pc,
   output logic          handler_valid,
   output logic          halted,
   output logic [15:0]   sr_out,
   output logic [AW-1:0] sp_out
);
   initial begin
      if (AW < 16 || AW > 64) $fatal(1, "exc_entry: AW must lie in 16..64");
      if (TRAP_W + 2 >= OFF_W || LVL_W + 2 >= OFF_W)
         $fatal(1, "exc_entry: offset field too narrow");
   end

   logic             take, is_irq;
   logic [OFF_W-1:0] off;

   exc_prio u_prio (
      .fault_valid (fault_valid),
      .fault_code  (fault_code),
      .trap_valid  (trap_valid),
      .trap_num    (trap_num),
      .trace_on    (sr_out[15]),
      .irq_level   (irq_level),
      .mask        (sr_out[10:8]),
      .take        (take),
      .is_irq      (is_irq),
      .off         (off)
   );

   exc_seq #(.AW(AW), .ODD_SP_HALT(ODD_SP_HALT), .RESET_SR(RESET_SR)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .insn_done     (insn_done),
      .ret_pc        (ret_pc),
      .take          (take),
      .is_irq        (is_irq),
      .off           (off),
      .irq_level     (irq_level),
      .ctx_we        (ctx_we),
      .ctx_sr        (ctx_sr),
      .ctx_usp       (ctx_usp),
      .ctx_ssp       (ctx_ssp),
      .vbase_we      (vbase_we),
      .vbase_in      (vbase_in),
      .bus_req       (bus_req),
      .bus_we        (bus_we),
      .bus_long      (bus_long),
      .bus_addr      (bus_addr),
      .bus_wdata     (bus_wdata),
      .bus_ack       (bus_ack),
      .bus_err       (bus_err),
      .bus_rdata     (bus_rdata),
      .busy          (busy),
      .handler_pc    (handler_pc),
      .handler_valid (handler_valid),
      .halted        (halted),
      .sr_out        (sr_out),
      .sp_out        (sp_out)
   );
endmodule

// File: tb/tb_exc_entry.sv
`timescale 1ns/1ps
module tb_exc_entry;
   localparam int AW = 32;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0;
   logic insn_done = 0, fault_valid = 0, trap_valid = 0, ctx_we = 0, vbase_we = 0;
   logic [AW-1:0] ret_pc = '0, ctx_usp = '0, ctx_ssp = '0, vbase_in = '0;
   logic [3:0] fault_code = '0, trap_num = '0;
   logic [2:0] irq_level = '0;
   logic [15:0] ctx_sr = '0;
   logic bus_req, bus_we, bus_long, bus_ack, bus_err, busy, handler_valid, halted;
   logic [AW-1:0] bus_addr, bus_wdata, bus_rdata, handler_pc, sp_out;
   logic [15:0] sr_out;

   exc_entry #(.AW(AW)) dut (.*);

   // behavioural memory model: vector table at tb_vbase, every access acked
   logic [31:0] vtab [0:63];
   logic [31:0] tb_vbase = '0;
   logic        err_on = 1'b0;
   logic [31:0] err_addr = '0;
   logic [31:0] vidx;
   assign bus_ack = bus_req;
   assign bus_err = err_on && bus_req && (bus_addr == err_addr);
   always_comb begin
      vidx = bus_addr - tb_vbase;
      bus_rdata = (vidx < 32'd256 && vidx[1:0] == 2'b00) ? vtab[vidx[7:2]] : '0;
   end

   // access log
   logic [31:0] wa [0:3];
   logic [31:0] wd [0:3];
   logic        wl [0:3];
   logic [31:0] ra [0:3];
   int wn = 0, rn = 0;
   logic log_clr = 1'b0;
   always @(posedge clk) begin
      if (log_clr) begin
         wn = 0; rn = 0;
      end else if (bus_req && bus_ack && !bus_err) begin
         if (bus_we) begin
            if (wn < 4) begin wa[wn] = bus_addr; wd[wn] = bus_wdata; wl[wn] = bus_long; end
            wn++;
         end else begin
            if (rn < 4) ra[rn] = bus_addr;
            rn++;
         end
      end
   end

   int checks = 0, errors = 0;
   logic done_flag = 1'b0;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // reference: table offset chosen by the requirements
   task automatic model(input logic fv, input logic [3:0] fc, input logic tv, input logic [3:0] tn,
                        input logic trace, input logic [2:0] il, input logic [2:0] mask,
                        output logic take, output logic irq, output logic [31:0] off);
      take = 1; irq = 0; off = 0;
      if (fv) begin
         if (fc inside {2, 3, 4, 5, 6, 7, 8, 10, 11, 14}) off = 32'(fc) * 4;
         else off = 32'h10;
      end else if (tv) off = 32'h80 + 32'(tn) * 4;
      else if (trace) off = 32'h24;
      else if (il != 0 && (il == 7 || il > mask)) begin irq = 1; off = 32'h60 + 32'(il) * 4; end
      else take = 0;
   endtask

   task automatic do_reset();
      rst_n = 0; tb_vbase = 0; err_on = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic load_ctx(input logic [15:0] s, input logic [31:0] u, input logic [31:0] sp);
      @(negedge clk);
      ctx_we = 1; ctx_sr = s; ctx_usp = u; ctx_ssp = sp;
      @(negedge clk);
      ctx_we = 0;
   endtask

   task automatic fire(input logic fv, input logic [3:0] fc, input logic tv, input logic [3:0] tn,
                       input logic [2:0] il, input logic [31:0] pc, input logic id);
      @(negedge clk); log_clr = 1;
      @(negedge clk); log_clr = 0;
      fault_valid = fv; fault_code = fc; trap_valid = tv; trap_num = tn;
      irq_level = il; ret_pc = pc; insn_done = id;
      @(negedge clk);
      insn_done = 0; fault_valid = 0; trap_valid = 0; irq_level = 0;
   endtask

   task automatic wait_end(output logic hv, output logic [31:0] hpc);
      hv = 0; hpc = 0;
      for (int i = 0; i < 20; i++) begin
         if (handler_valid) begin hv = 1; hpc = handler_pc; break; end
         if (halted) break;
         @(negedge clk);
      end
   endtask

   // full entry: predict, drive, compare the whole frame and result
   task automatic entry(input string req, input logic fv, input logic [3:0] fc, input logic tv,
                        input logic [3:0] tn, input logic [2:0] il, input logic [31:0] pc);
      logic take, irq, hv;
      logic [31:0] off, hpc, ssp0, exp_sp;
      logic [15:0] sr0, exp_sr;
      sr0 = sr_out;
      ssp0 = sr0[13] ? sp_out : 32'hx;
      model(fv, fc, tv, tn, sr0[15], il, sr0[10:8], take, irq, off);
      exp_sr = sr0 | 16'h2000;
      exp_sr[15] = 1'b0;
      if (irq) exp_sr[10:8] = il;
      fire(fv, fc, tv, tn, il, pc, 1'b1);
      wait_end(hv, hpc);
      chk(req, "taken", {31'd0, hv}, {31'd0, take});
      chk(req, "read addr", ra[0], tb_vbase + off);
      chk(req, "handler", hpc, vtab[off[7:2]]);
      chk("R7", "sr after entry", {16'd0, sr_out}, {16'd0, exp_sr});
      chk("R8", "write count", wn, 2);
      chk("R8", "pc push data", wd[0], pc);
      chk("R8", "pc push long", {31'd0, wl[0]}, 32'd1);
      chk("R8", "sr push data", wd[1], {16'd0, sr0});
      chk("R8", "sr push word", {31'd0, wl[1]}, 32'd0);
      chk("R8", "sr push below pc", wd[1] == wd[1] ? wa[0] - wa[1] : 0, 32'd2);
      if (sr0[13]) begin
         exp_sp = ssp0 - 6;
         chk("R8", "final ssp", sp_out, exp_sp);
         chk("R8", "pc push addr", wa[0], ssp0 - 4);
      end
      @(negedge clk);
      chk("R9", "strobe one cycle", {31'd0, handler_valid}, 32'd0);
   endtask

   logic hv;
   logic [31:0] hpc, sp_keep;

   initial begin
      for (int i = 0; i < 64; i++) vtab[i] = 32'h1000_0000 + 32'(i) * 32'h100;
      do_reset();
      // R1 reset state
      chk("R1", "sr", {16'd0, sr_out}, 32'h2700);
      chk("R1", "sp", sp_out, 32'd0);
      chk("R1", "busy", {31'd0, busy}, 0);
      chk("R1", "halted", {31'd0, halted}, 0);
      chk("R1", "handler_valid", {31'd0, handler_valid}, 0);

      // R4 R8 from user mode, base still at its reset value 0 (R1)
      load_ctx(16'h0000, 32'h4000, 32'h8000);
      chk("R7", "user sp shown", sp_out, 32'h4000);
      fire(1, 4'd5, 0, 0, 0, 32'h00AB_CDE0, 1'b1);
      wait_end(hv, hpc);
      chk("R4", "div0 read addr", ra[0], 32'h14);
      chk("R9", "handler", hpc, vtab[5]);
      chk("R8", "pc addr", wa[0], 32'h7FFC);
      chk("R8", "sr addr", wa[1], 32'h7FFA);
      chk("R8", "old sr stacked", wd[1], 32'h0);
      chk("R7", "sr", {16'd0, sr_out}, 32'h2000);
      chk("R7", "sp is ssp", sp_out, 32'h7FFA);

      // R3 priority mixes (supervisor, trace on, mask 0)
      load_ctx(16'hA000, 32'h4000, 32'h9000);
      entry("R3", 1, 4'd2, 1, 4'd3, 3'd7, 32'h100);
      load_ctx(16'hA000, 32'h4000, 32'h9000);
      entry("R3", 0, 0, 1, 4'd9, 3'd5, 32'h104);
      // R12 trace beats interrupt
      load_ctx(16'h8000, 32'h4000, 32'h9000);
      entry("R12", 0, 0, 0, 0, 3'd5, 32'h108);
      // R6 interrupt above mask, mask raised
      load_ctx(16'h0200, 32'h4000, 32'h9000);
      entry("R6", 0, 0, 0, 0, 3'd3, 32'h10C);
      // R6 level 7 against mask 7
      load_ctx(16'h2700, 32'h4000, 32'h9000);
      entry("R6", 0, 0, 0, 0, 3'd7, 32'h110);
      // R4 unlisted and format codes
      load_ctx(16'h2000, 32'h4000, 32'h9000);
      entry("R4", 1, 4'd9, 0, 0, 0, 32'h114);
      entry("R4", 1, 4'd14, 0, 0, 0, 32'h118);
      // R5 trap 15
      entry("R5", 0, 0, 1, 4'd15, 0, 32'h11C);

      // R6 level equal to mask is refused
      load_ctx(16'h0200, 32'h4000, 32'h9000);
      fire(0, 0, 0, 0, 3'd2, 32'h200, 1'b1);
      repeat (4) @(negedge clk);
      chk("R6", "equal level ignored busy", {31'd0, busy}, 0);
      chk("R6", "equal level no writes", wn, 0);
      chk("R6", "sr untouched", {16'd0, sr_out}, 32'h0200);
      // R2 cause without insn_done
      fire(1, 4'd4, 0, 0, 0, 32'h204, 1'b0);
      repeat (4) @(negedge clk);
      chk("R2", "no entry", wn + rn, 0);
      chk("R2", "sp untouched", sp_out, 32'h4000);
      // R12 trace off, nothing pending: no entry
      fire(0, 0, 0, 0, 0, 32'h208, 1'b1);
      repeat (4) @(negedge clk);
      chk("R12", "no trace entry", wn + rn, 0);

      // R9 relocated base
      @(negedge clk); vbase_we = 1; vbase_in = 32'h0001_0000;
      @(negedge clk); vbase_we = 0; tb_vbase = 32'h0001_0000;
      load_ctx(16'h2000, 32'h4000, 32'h9000);
      fire(0, 0, 1, 4'd0, 0, 32'h300, 1'b1);
      wait_end(hv, hpc);
      chk("R9", "relocated read", ra[0], 32'h0001_0080);
      chk("R9", "relocated handler", hpc, vtab[32]);

      // R10 zero vector falls back to 0x3C
      vtab[33] = 0;
      fire(0, 0, 1, 4'd1, 0, 32'h304, 1'b1);
      wait_end(hv, hpc);
      chk("R10", "first read", ra[0], 32'h0001_0084);
      chk("R10", "fallback read", ra[1], 32'h0001_003C);
      chk("R10", "fallback handler", hpc, vtab[15]);

      // R13 context write during entry ignored
      load_ctx(16'h2000, 32'h4000, 32'h9000);
      fire(0, 0, 1, 4'd2, 0, 32'h308, 1'b1);
      ctx_we = 1; ctx_sr = 16'h0000; ctx_ssp = 32'h1230; vbase_we = 1; vbase_in = 32'h0;
      @(negedge clk);
      ctx_we = 0; vbase_we = 0;
      wait_end(hv, hpc);
      chk("R13", "sr kept", {16'd0, sr_out}, 32'h2000);
      chk("R13", "ssp kept", sp_out, 32'h8FFA);
      chk("R13", "base kept", ra[0], 32'h0001_0088);

      // R10 both zero -> halt
      vtab[15] = 0;
      fire(0, 0, 1, 4'd1, 0, 32'h30C, 1'b1);
      wait_end(hv, hpc);
      chk("R10", "halt on double zero", {31'd0, halted}, 1);
      chk("R10", "no handler", {31'd0, hv}, 0);
      repeat (3) @(negedge clk);
      chk("R11", "stays halted", {31'd0, halted}, 1);
      chk("R11", "bus quiet", {31'd0, bus_req}, 0);
      vtab[15] = 32'h1000_0F00; vtab[33] = 32'h1000_2100;

      // R11 odd stack pointer
      do_reset();
      load_ctx(16'h2000, 32'h4000, 32'h9001);
      fire(0, 0, 1, 4'd3, 0, 32'h400, 1'b1);
      wait_end(hv, hpc);
      chk("R11", "odd sp halts", {31'd0, halted}, 1);
      chk("R11", "odd sp no access", wn + rn, 0);

      // R11 bus error on pc push
      do_reset();
      load_ctx(16'h2000, 32'h4000, 32'h9000);
      err_on = 1; err_addr = 32'h8FFC;
      fire(0, 0, 1, 4'd3, 0, 32'h404, 1'b1);
      wait_end(hv, hpc);
      chk("R11", "bus error halts", {31'd0, halted}, 1);
      chk("R11", "no vector read", rn, 0);
      err_on = 0;

      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule